// File: doc/BRIEF.md
# Buck Converter Light-Load Mode Controller

This block decides, for one synchronous buck channel, whether the power stage runs in fixed-frequency PWM or in a hysteretic pulse-skipping mode for light loads. Once per switching clock, at the close of low-side conduction, it is given the sign of the phase node. A positive sign means the inductor current has reversed. A long unbroken run of one sign moves the channel into the other mode. A run of one or two samples does not, so the mode does not jitter when the load sits near the boundary.

In PWM mode the high-side and low-side requests follow the regulation loop's PWM request. In hysteretic mode, energy is delivered in bursts. A burst opens when the output falls under the lower hysteresis limit and closes when the output reaches the upper limit. During a burst the gates still follow the clocked PWM request, so turn-on stays on the main clock edges. Between bursts both switches stay off, which emulates a diode.

If the output sags below the regulation floor while in hysteretic mode, the controller returns to PWM at once. All outputs are registered.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `rst` is high, or on any edge where `en` is low, the controller goes to PWM mode (`mode_hyst` = 0) with `hs_req` = `ls_req` = 0. The consecutive-sample run count is also cleared.
- R2: In PWM mode with `en` high, each edge loads `hs_req` = `pwm_req` and `ls_req` = not `pwm_req` from the inputs present at that edge.
- R3: In PWM mode, the eighth consecutive valid sample with `ph_pos` = 1 (a valid sample is an edge with `ls_win` = 1) sets `mode_hyst` to 1 on that same edge.
- R4: A valid sample whose polarity matches the current mode restarts the run. Eight further opposing samples are then needed before the mode changes.
- R5: Edges with `ls_win` = 0 neither advance nor break the run. Without a valid sample, the mode changes only through R1 or R9.
- R6: On the edge that enters hysteretic mode, both gate requests are 0.
- R7: In hysteretic mode, the gates are 0 until an edge with `out_low` = 1 opens a burst. From that edge the gates follow `pwm_req` as in R2. An edge with `out_high` = 1 closes the burst and forces both gates to 0. `out_high` takes precedence over `out_low`.
- R8: In hysteretic mode, eight consecutive valid samples with `ph_pos` = 0 return the controller to PWM on the edge of the eighth sample. From that edge the gates follow R2.
- R9: In hysteretic mode, an edge with `out_sag` = 1 returns the controller to PWM on that edge, and the gates follow R2. In PWM mode, `out_sag` has no effect.
- R10: `hs_req` and `ls_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main switching clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low forces the idle PWM state |
| ls_win | input | 1 | Marks the edge where the phase polarity sample is valid |
| ph_pos | input | 1 | Phase-node polarity sample, 1 = positive (reverse current) |
| out_low | input | 1 | Output below the lower hysteresis limit |
| out_high | input | 1 | Output at or above the upper hysteresis limit |
| out_sag | input | 1 | Output below the hysteretic regulation floor |
| pwm_req | input | 1 | High-side request from the regulation loop |
| hs_req | output | 1 | High-side gate request |
| ls_req | output | 1 | Low-side gate request |
| mode_hyst | output | 1 | 1 = hysteretic mode, 0 = PWM mode |

## Verification
The properties assume that every input is synchronous to `clk` and settled before each rising edge. They make no assumption about how the comparator flags relate to one another; `out_low` and `out_high` may both be high, for example. The bench changes inputs only on falling edges and reads results one time unit after the following rising edge, so each check sees exactly one edge of effect. Flag combinations that a real output could not produce together are still applied on purpose, to exercise the R7 precedence rule.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;

    typedef enum logic {
        MODE_PWM  = 1'b0,
        MODE_HYST = 1'b1
    } mode_e;

    typedef struct packed {
        logic hs;
        logic ls;
    } gate_t;

    localparam gate_t GATES_OFF = '{hs: 1'b0, ls: 1'b0};

    // Complementary drive derived from the loop request: never both on.
    function automatic gate_t gates_from_req(input logic req);
        gate_t g;
        g.hs = req;
        g.ls = ~req;
        return g;
    endfunction

endpackage

// File: rtl/buck_mode_runcnt.sv
module buck_mode_runcnt #(
    parameter int RUN_LEN = 8,
    parameter int CNT_W   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic smp_vld,
    input  logic smp_opp,
    output logic run_done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // The current sample completes the run when LAST opposing samples precede it.
    assign run_done = smp_vld & smp_opp & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (smp_vld) begin
            if (!smp_opp)
                cnt_q <= '0;
            else if (cnt_q != LAST)
                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/buck_mode_fsm.sv
module buck_mode_fsm
    import buck_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  run_done,
    input  logic  out_sag,
    input  logic  out_low,
    input  logic  out_high,
    output mode_e mode_q,
    output mode_e mode_nxt,
    output logic  entering,
    output logic  burst_nxt
);
    logic burst_q;

    always_comb begin
        if (!en) begin
            mode_nxt = MODE_PWM;
        end else begin
            unique case (mode_q)
                MODE_PWM:  mode_nxt = run_done ? MODE_HYST : MODE_PWM;
                MODE_HYST: mode_nxt = (run_done || out_sag) ? MODE_PWM : MODE_HYST;
                default:   mode_nxt = MODE_PWM;
            endcase
        end
    end

    assign entering = (mode_q == MODE_PWM) && (mode_nxt == MODE_HYST);

    always_comb begin
        if (mode_nxt != MODE_HYST || entering)
            burst_nxt = 1'b0;
        else if (out_high)
            burst_nxt = 1'b0;
        else if (out_low)
            burst_nxt = 1'b1;
        else
            burst_nxt = burst_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_PWM;
            burst_q <= 1'b0;
        end else begin
            mode_q  <= mode_nxt;
            burst_q <= burst_nxt;
        end
    end
endmodule

// File: rtl/buck_mode_gate.sv
module buck_mode_gate
    import buck_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  mode_e mode_nxt,
    input  logic  entering,
    input  logic  burst_nxt,
    input  logic  pwm_req,
    output logic  hs_req,
    output logic  ls_req
);
    gate_t g_d;
    gate_t g_q;

    always_comb begin
        if (!en)
            g_d = GATES_OFF;
        else if (mode_nxt == MODE_PWM)
            g_d = gates_from_req(pwm_req);
        else if (burst_nxt && !entering)
            g_d = gates_from_req(pwm_req);
        else
            g_d = GATES_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst)
            g_q <= GATES_OFF;
        else
            g_q <= g_d;
    end

    assign hs_req = g_q.hs;
    assign ls_req = g_q.ls;
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
    import buck_mode_pkg::*;
#(
    parameter int RUN_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic ls_win,
    input  logic ph_pos,
    input  logic out_low,
    input  logic out_high,
    input  logic out_sag,
    input  logic pwm_req,
    output logic hs_req,
    output logic ls_req,
    output logic mode_hyst
);
    localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;

    mode_e mode_q;
    mode_e mode_nxt;
    logic  entering;
    logic  burst_nxt;
    logic  run_done;
    logic  smp_opp;
    logic  cnt_clr;

    // A sample opposes the mode when its sign points to the other mode.
    assign smp_opp = ph_pos ^ (mode_q == MODE_HYST);
    assign cnt_clr = ~en | (mode_nxt != mode_q);

    buck_mode_runcnt #(
        .RUN_LEN (RUN_LEN),
        .CNT_W   (CNT_W)
    ) u_run (
        .clk      (clk),
        .rst      (rst),
        .clr      (cnt_clr),
        .smp_vld  (ls_win),
        .smp_opp  (smp_opp),
        .run_done (run_done)
    );

    buck_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .run_done  (run_done),
        .out_sag   (out_sag),
        .out_low   (out_low),
        .out_high  (out_high),
        .mode_q    (mode_q),
        .mode_nxt  (mode_nxt),
        .entering  (entering),
        .burst_nxt (burst_nxt)
    );

    buck_mode_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode_nxt  (mode_nxt),
        .entering  (entering),
        .burst_nxt (burst_nxt),
        .pwm_req   (pwm_req),
        .hs_req    (hs_req),
        .ls_req    (ls_req)
    );

    assign mode_hyst = (mode_q == MODE_HYST);
endmodule

// File: rtl/buck_mode_ctrl_chk.sv
module buck_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic ls_win,
    input logic out_sag,
    input logic pwm_req,
    input logic hs_req,
    input logic ls_req,
    input logic mode_hyst
);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(hs_req && ls_req));

    a_r1_disable_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!hs_req && !ls_req && !mode_hyst));

    a_r6_entry_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_hyst) |-> (!hs_req && !ls_req));

    a_r9_sag_exit: assert property (@(posedge clk) disable iff (rst)
        (en && mode_hyst && out_sag) |=> !mode_hyst);

    a_r2_pwm_follow: assert property (@(posedge clk) disable iff (rst)
        (en && !mode_hyst && !ls_win) |=> (hs_req == $past(pwm_req) && ls_req == !$past(pwm_req)));

    a_r5_hold_without_sample: assert property (@(posedge clk) disable iff (rst)
        (en && !ls_win && !(mode_hyst && out_sag)) |=> (mode_hyst == $past(mode_hyst)));
endmodule

bind buck_mode_ctrl buck_mode_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .ls_win    (ls_win),
    .out_sag   (out_sag),
    .pwm_req   (pwm_req),
    .hs_req    (hs_req),
    .ls_req    (ls_req),
    .mode_hyst (mode_hyst)
);

// File: tb/buck_mode_ctrl_test.sv
module buck_mode_ctrl_test;
    logic clk = 1'b0;
    logic rst, en, ls_win, ph_pos, out_low, out_high, out_sag, pwm_req;
    logic hs_req, ls_req, mode_hyst;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    buck_mode_ctrl uut (
        .clk(clk), .rst(rst), .en(en), .ls_win(ls_win), .ph_pos(ph_pos),
        .out_low(out_low), .out_high(out_high), .out_sag(out_sag),
        .pwm_req(pwm_req), .hs_req(hs_req), .ls_req(ls_req), .mode_hyst(mode_hyst)
    );

    task automatic chk(input string req, input logic m, input logic h, input logic l);
        n_chk++;
        if (mode_hyst !== m || hs_req !== h || ls_req !== l || (hs_req && ls_req)) begin
            n_bad++;
            $display("FAIL %s: got mode=%b hs=%b ls=%b, expected mode=%b hs=%b ls=%b",
                     req, mode_hyst, hs_req, ls_req, m, h, l);
        end
    endtask

    // One edge: drive at the falling edge, observe just after the rising edge.
    task automatic cyc(input logic e, input logic w, input logic p, input logic req,
                       input logic lo, input logic hi, input logic sg);
        @(negedge clk);
        en = e; ls_win = w; ph_pos = p; pwm_req = req;
        out_low = lo; out_high = hi; out_sag = sg;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b1; ls_win = 1'b0; ph_pos = 1'b0; pwm_req = 1'b1;
        out_low = 1'b0; out_high = 1'b0; out_sag = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic enter_hyst();
        for (int i = 0; i < 8; i++) cyc(1, 1, 1, 1, 0, 0, 0);
    endtask

    task automatic t_pwm_follow();
        do_reset();
        cyc(1, 0, 0, 1, 0, 0, 0); chk("R2 req high", 0, 1, 0);
        cyc(1, 0, 1, 0, 0, 0, 1); chk("R2 req low, sag ignored R9", 0, 0, 1);
        cyc(1, 0, 0, 1, 1, 1, 0); chk("R2 limit flags ignored", 0, 1, 0);
    endtask

    task automatic t_enter();
        do_reset();
        for (int i = 0; i < 7; i++) cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R3 seven samples stay PWM", 0, 1, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R3 R6 eighth sample enters idle", 1, 0, 0);
    endtask

    task automatic t_break();
        do_reset();
        for (int i = 0; i < 7; i++) cyc(1, 1, 1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 7; i++) cyc(1, 1, 1, 0, 0, 0, 0);
        chk("R4 broken run stays PWM", 0, 0, 1);
        cyc(1, 1, 1, 0, 0, 0, 0);
        chk("R4 full run after restart", 1, 0, 0);
    endtask

    task automatic t_gaps();
        do_reset();
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R5 gaps neither count nor break", 0, 1, 0);
        cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R5 eighth valid sample", 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0, 0);
        chk("R5 no sample keeps mode", 1, 0, 0);
    endtask

    task automatic t_burst();
        do_reset();
        enter_hyst();
        cyc(1, 0, 1, 1, 0, 0, 0); chk("R7 idle between bursts", 1, 0, 0);
        cyc(1, 0, 1, 1, 1, 0, 0); chk("R7 burst opens", 1, 1, 0);
        cyc(1, 0, 1, 0, 0, 0, 0); chk("R7 burst held", 1, 0, 1);
        cyc(1, 0, 1, 1, 1, 1, 0); chk("R7 upper limit wins", 1, 0, 0);
        cyc(1, 0, 1, 1, 0, 0, 0); chk("R7 idle after burst", 1, 0, 0);
    endtask

    task automatic t_exit_run();
        do_reset();
        enter_hyst();
        for (int i = 0; i < 7; i++) cyc(1, 1, 0, 1, 0, 0, 0);
        chk("R8 seven negatives stay hysteretic", 1, 0, 0);
        cyc(1, 1, 0, 1, 0, 0, 0);
        chk("R8 eighth negative back to PWM", 0, 1, 0);
    endtask

    task automatic t_sag();
        do_reset();
        enter_hyst();
        cyc(1, 0, 1, 0, 0, 0, 1);
        chk("R9 sag exits at once", 0, 0, 1);
    endtask

    task automatic t_disable();
        do_reset();
        enter_hyst();
        cyc(0, 0, 1, 1, 0, 0, 0); chk("R1 disable idles", 0, 0, 0);
        for (int i = 0; i < 5; i++) cyc(1, 1, 1, 1, 0, 0, 0);
        cyc(0, 1, 1, 1, 0, 0, 0); chk("R1 disable mid-run", 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0, 0, 0);
        chk("R1 run count cleared by disable", 0, 1, 0);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_pwm_follow();
        t_enter();
        t_break();
        t_gaps();
        t_burst();
        t_exit_run();
        t_sag();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule